// File: doc/BRIEF.md
# Union-Find Cluster Growth Array

This block is the growth and merge stage of a union-find decoder for one stabilizer type of a surface-code lattice. A grid of `ROWS` x `COLS` node cells takes a frame of syndrome bits in one strobe. It then grows clusters around every flagged node in parallel, one half-edge per cycle. Clusters that touch are merged by propagating the smallest node index across fully grown edges. The run stops once no odd cluster is left that has not reached a lattice boundary.

Each lattice edge can be masked at runtime. A mode input selects single-patch or merged-patch decoding. In single-patch mode, the column of horizontal edges at the patch seam is cut off. The result is the set of grown edges, the grown boundary edges and a cluster label per node, which a later stage uses to peel out a correction. A cycle limit guards against a run that never settles, for example an odd cluster walled in by masked edges.

Top module: `uf_grow_array`

## Requirements
- R1: A cycle with `load_i` high captures `syndrome_i`, clears all edge growth, resets every node label to its own index (node (r,c) has index r*COLS+c, label at `label_o[index*LW +: LW]`) and starts a new run. After reset, all outputs are zero except the labels, which hold their own indices.
- R2: Each growth cycle, every node that is in a cluster and active adds one half-step to each enabled edge touching it, including its boundary edges. Growth saturates at two, so an edge whose two ends both grow in the same cycle goes from 0 straight to full. Edge growth never decreases within a run.
- R3: An edge connects when its growth is full and it is enabled, and `edge_full_o` shows exactly the connecting edges. The horizontal edge (r,c)-(r,c+1) is bit r*(COLS-1)+c. The vertical edge (r,c)-(r+1,c) is bit ROWS*(COLS-1)+r*COLS+c.
- R4: Each cycle, every node takes the minimum of its own label and the labels of neighbours across connecting edges, so labels move one hop per cycle. A label never increases within a run and never exceeds its node's index.
- R5: A node is in a cluster when it holds a syndrome or has a connecting or full boundary edge. A node is active when the nodes sharing its label hold an odd number of syndromes and none of them has a full boundary edge. Only nodes that are both in a cluster and active grow.
- R6: `done_o` rises the cycle after an iteration finds no growing node and no label change, and it holds until the next load. A run that needs k iterations shows `done_o` on the k-th clock edge after the load edge; an empty frame takes one iteration.
- R7: If `MAX_CYC` iterations pass without convergence, `overflow_o` rises, growth stops and `done_o` stays low. The two flags are never high together.
- R8: A disabled edge neither grows nor connects, and a mask change applies to the very next clock edge.
- R9: With `merged_i` low, the horizontal edges between columns SEAM_COL-1 and SEAM_COL are forced off, so the two halves never share a label. With `merged_i` high, only `edge_en_i` applies.
- R10: Each row has a left boundary edge on column 0 (`bnd_full_o[r]`) and a right boundary edge on column COLS-1 (`bnd_full_o[ROWS+r]`). These edges are always enabled and grow like lattice edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Capture syndrome frame and start a run |
| syndrome_i | input | ROWS*COLS | Syndrome bit per node |
| edge_en_i | input | NE | Per-edge enable mask |
| merged_i | input | 1 | 1: merged-patch edge set, 0: seam cut |
| edge_full_o | output | NE | Connecting edges |
| bnd_full_o | output | 2*ROWS | Fully grown boundary edges |
| label_o | output | ROWS*COLS*LW | Cluster label per node |
| done_o | output | 1 | Run converged |
| overflow_o | output | 1 | Cycle limit hit without convergence |

## Verification
The assertions assume that `load_i` is only pulsed for one cycle between runs, and that the mask and mode change only while a run is idle or as a deliberate switch. They do not assume the grid converges: a walled-in cluster must end in overflow. The stimulus loads each frame with a single strobe and keeps the mask steady until the result flag appears. It mixes empty frames, corner and seam-straddling pairs, walled-in nodes and random frames with sparsely masked edges in both modes. Each frame is checked against a cycle-stepped behavioural union-find model in the bench.

// File: rtl/uf_pkg.sv
package uf_pkg;
  typedef enum logic [1:0] {G_NONE = 2'd0, G_HALF = 2'd1, G_FULL = 2'd2} grow_e;

  function automatic int h_idx(int cols, int r, int c);
    return r * (cols - 1) + c;
  endfunction

  function automatic int v_idx(int rows, int cols, int r, int c);
    return rows * (cols - 1) + r * cols + c;
  endfunction
endpackage

// File: rtl/uf_edge_cell.sv
module uf_edge_cell
  import uf_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic upd_i,
  input  logic en_i,
  input  logic inc_a_i,
  input  logic inc_b_i,
  output logic full_o
);
  grow_e      g_q, g_d;
  logic [2:0] sum;

  always_comb begin
    sum = 3'(g_q) + 3'(inc_a_i) + 3'(inc_b_i);
    g_d = (sum >= 3'd2) ? G_FULL : grow_e'(sum[1:0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               g_q <= G_NONE;
    else if (clr_i)            g_q <= G_NONE;
    else if (upd_i && en_i)    g_q <= g_d;
  end

  assign full_o = en_i && (g_q == G_FULL);

  assert_growth_monotone_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> 2'(g_q) >= $past(2'(g_q)));
  assert_growth_bounded_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    2'(g_q) <= 2'd2);
  assert_masked_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> g_q == $past(g_q));
endmodule

// File: rtl/uf_node_cell.sv
module uf_node_cell #(
  parameter int LW  = 5,
  parameter int IDX = 0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic                upd_i,
  input  logic                syn_i,
  input  logic [3:0][LW-1:0]  nb_lab_i,
  input  logic [3:0]          nb_con_i,
  input  logic                bnd_con_i,
  output logic                syn_o,
  output logic [LW-1:0]       lab_o,
  output logic [LW-1:0]       lab_nxt_o,
  output logic                in_cl_o
);
  logic          syn_q;
  logic [LW-1:0] lab_q, lab_min;

  always_comb begin
    lab_min = lab_q;
    for (int i = 0; i < 4; i++)
      if (nb_con_i[i] && (nb_lab_i[i] < lab_min)) lab_min = nb_lab_i[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      syn_q <= 1'b0;
      lab_q <= LW'(IDX);
    end else if (load_i) begin
      syn_q <= syn_i;
      lab_q <= LW'(IDX);
    end else if (upd_i) begin
      lab_q <= lab_min;
    end
  end

  assign syn_o     = syn_q;
  assign lab_o     = lab_q;
  assign lab_nxt_o = lab_min;
  assign in_cl_o   = syn_q | (|nb_con_i) | bnd_con_i;

  assert_label_not_above_index_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lab_q <= LW'(IDX));
  assert_label_never_rises_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> lab_q <= $past(lab_q));
  assert_syndrome_held_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(syn_q));
endmodule

// File: rtl/uf_cluster_eval.sv
module uf_cluster_eval #(
  parameter int N  = 20,
  parameter int LW = 5
) (
  input  logic [N-1:0]          syn_i,
  input  logic [N-1:0][LW-1:0]  lab_i,
  input  logic [N-1:0]          touch_i,
  output logic [N-1:0]          active_o
);
  always_comb begin
    for (int n = 0; n < N; n++) begin
      logic par, bnd;
      par = 1'b0;
      bnd = 1'b0;
      for (int k = 0; k < N; k++) begin
        if (lab_i[k] == lab_i[n]) begin
          par = par ^ syn_i[k];
          bnd = bnd | touch_i[k];
        end
      end
      active_o[n] = par & ~bnd;
    end
  end
endmodule

// File: rtl/uf_grow_array.sv
module uf_grow_array
  import uf_pkg::*;
#(
  parameter int ROWS     = 4,
  parameter int COLS     = 5,
  parameter int SEAM_COL = COLS / 2,
  parameter int MAX_CYC  = 64,
  localparam int N  = ROWS * COLS,
  localparam int NH = ROWS * (COLS - 1),
  localparam int NV = (ROWS - 1) * COLS,
  localparam int NE = NH + NV,
  localparam int NB = 2 * ROWS,
  localparam int LW = $clog2(N)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [N-1:0]    syndrome_i,
  input  logic [NE-1:0]   edge_en_i,
  input  logic            merged_i,
  output logic [NE-1:0]   edge_full_o,
  output logic [NB-1:0]   bnd_full_o,
  output logic [N*LW-1:0] label_o,
  output logic            done_o,
  output logic            overflow_o
);
  localparam int CW = $clog2(MAX_CYC + 1);

  logic                        run_q, done_q, ovf_q;
  logic [CW-1:0]               cnt_q;
  logic [NE-1:0]               en_eff, efull;
  logic [NB-1:0]               bfull;
  logic [N-1:0][LW-1:0]        lab, lab_nxt;
  logic [N-1:0]                syn, in_cl, active, touch, grow;
  logic [N-1:0][3:0][LW-1:0]   nb_lab;
  logic [N-1:0][3:0]           nb_con;
  logic                        fin, lim, upd;

  // effective enables: seam column cut in single-patch mode
  for (genvar r = 0; r < ROWS; r++) begin : g_en_r
    for (genvar c = 0; c < COLS - 1; c++) begin : g_en_c
      localparam int E = h_idx(COLS, r, c);
      if (c == SEAM_COL - 1) begin : g_seam
        assign en_eff[E] = edge_en_i[E] & merged_i;
      end else begin : g_plain
        assign en_eff[E] = edge_en_i[E];
      end
    end
  end
  assign en_eff[NE-1:NH] = edge_en_i[NE-1:NH];

  // neighbour order: 0 left, 1 right, 2 up, 3 down
  always_comb begin
    touch  = '0;
    nb_lab = '0;
    nb_con = '0;
    for (int r = 0; r < ROWS; r++) begin
      touch[r*COLS]          = touch[r*COLS] | bfull[r];
      touch[r*COLS+COLS-1]   = touch[r*COLS+COLS-1] | bfull[ROWS+r];
      for (int c = 0; c < COLS; c++) begin
        int n;
        n = r * COLS + c;
        if (c > 0) begin
          nb_con[n][0] = efull[h_idx(COLS, r, c - 1)];
          nb_lab[n][0] = lab[n-1];
        end
        if (c < COLS - 1) begin
          nb_con[n][1] = efull[h_idx(COLS, r, c)];
          nb_lab[n][1] = lab[n+1];
        end
        if (r > 0) begin
          nb_con[n][2] = efull[v_idx(ROWS, COLS, r - 1, c)];
          nb_lab[n][2] = lab[n-COLS];
        end
        if (r < ROWS - 1) begin
          nb_con[n][3] = efull[v_idx(ROWS, COLS, r, c)];
          nb_lab[n][3] = lab[n+COLS];
        end
      end
    end
  end

  for (genvar n = 0; n < N; n++) begin : g_node
    uf_node_cell #(.LW(LW), .IDX(n)) u_node (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (load_i),
      .upd_i     (upd),
      .syn_i     (syndrome_i[n]),
      .nb_lab_i  (nb_lab[n]),
      .nb_con_i  (nb_con[n]),
      .bnd_con_i (touch[n]),
      .syn_o     (syn[n]),
      .lab_o     (lab[n]),
      .lab_nxt_o (lab_nxt[n]),
      .in_cl_o   (in_cl[n])
    );
    assign label_o[n*LW +: LW] = lab[n];
  end

  uf_cluster_eval #(.N(N), .LW(LW)) u_eval (
    .syn_i    (syn),
    .lab_i    (lab),
    .touch_i  (touch),
    .active_o (active)
  );

  assign fin  = ~|(in_cl & active) && (lab_nxt == lab);
  assign lim  = (cnt_q == CW'(MAX_CYC - 1));
  assign upd  = run_q & ~fin & ~lim;
  assign grow = {N{upd}} & in_cl & active;

  for (genvar r = 0; r < ROWS; r++) begin : g_eh_r
    for (genvar c = 0; c < COLS - 1; c++) begin : g_eh_c
      localparam int E = h_idx(COLS, r, c);
      uf_edge_cell u_edge (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (load_i),
        .upd_i   (upd),
        .en_i    (en_eff[E]),
        .inc_a_i (grow[r*COLS+c]),
        .inc_b_i (grow[r*COLS+c+1]),
        .full_o  (efull[E])
      );
    end
  end

  for (genvar r = 0; r < ROWS - 1; r++) begin : g_ev_r
    for (genvar c = 0; c < COLS; c++) begin : g_ev_c
      localparam int E = v_idx(ROWS, COLS, r, c);
      uf_edge_cell u_edge (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (load_i),
        .upd_i   (upd),
        .en_i    (en_eff[E]),
        .inc_a_i (grow[r*COLS+c]),
        .inc_b_i (grow[(r+1)*COLS+c]),
        .full_o  (efull[E])
      );
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_bnd
    uf_edge_cell u_left (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (load_i),
      .upd_i   (upd),
      .en_i    (1'b1),
      .inc_a_i (grow[r*COLS]),
      .inc_b_i (1'b0),
      .full_o  (bfull[r])
    );
    uf_edge_cell u_right (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (load_i),
      .upd_i   (upd),
      .en_i    (1'b1),
      .inc_a_i (grow[r*COLS+COLS-1]),
      .inc_b_i (1'b0),
      .full_o  (bfull[ROWS+r])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (load_i) begin
      run_q  <= 1'b1;
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (run_q) begin
      if (fin) begin
        done_q <= 1'b1;
        run_q  <= 1'b0;
      end else if (lim) begin
        ovf_q  <= 1'b1;
        run_q  <= 1'b0;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign edge_full_o = efull;
  assign bnd_full_o  = bfull;
  assign done_o      = done_q;
  assign overflow_o  = ovf_q;

  assert_flags_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_q && ovf_q));
  assert_no_overflow_early_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_q) |-> $past(cnt_q) == CW'(MAX_CYC - 1));
  assert_done_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !load_i) |=> done_q);
  assert_idle_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !load_i) |=> $stable(label_o) && $stable(bnd_full_o));

  for (genvar r = 0; r < ROWS; r++) begin : g_seam_chk
    assert_seam_cut_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !merged_i |-> !edge_full_o[h_idx(COLS, r, SEAM_COL - 1)]);
  end
endmodule

// File: tb/uf_grow_array_bench.sv
module uf_grow_array_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 4;
  localparam int COLS = 5;
  localparam int SEAM = COLS / 2;
  localparam int MAXC = 64;
  localparam int N  = ROWS * COLS;
  localparam int NH = ROWS * (COLS - 1);
  localparam int NE = NH + (ROWS - 1) * COLS;
  localparam int NB = 2 * ROWS;
  localparam int LW = $clog2(N);

  typedef struct {
    logic [NE-1:0]   ef;
    logic [NB-1:0]   bf;
    logic [N*LW-1:0] lab;
    bit              done;
    bit              ovf;
    int              cycles;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            load = 1'b0;
  logic [N-1:0]    syn = '0;
  logic [NE-1:0]   mask = '1;
  logic            merged = 1'b1;
  logic [NE-1:0]   edge_full;
  logic [NB-1:0]   bnd_full;
  logic [N*LW-1:0] label;
  logic            done, ovf;

  int   checks = 0, failures = 0, cyc = 0, last_cyc = 0;
  bit   busy = 0, finished = 0;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  uf_grow_array #(.ROWS(ROWS), .COLS(COLS), .SEAM_COL(SEAM), .MAX_CYC(MAXC)) u_uf_grow_array (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .load_i      (load),
    .syndrome_i  (syn),
    .edge_en_i   (mask),
    .merged_i    (merged),
    .edge_full_o (edge_full),
    .bnd_full_o  (bnd_full),
    .label_o     (label),
    .done_o      (done),
    .overflow_o  (ovf)
  );

  function automatic int hx(int r, int c); return r * (COLS - 1) + c; endfunction
  function automatic int vx(int r, int c); return NH + r * COLS + c; endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [N*LW-1:0] ident_labels();
    logic [N*LW-1:0] v;
    for (int n = 0; n < N; n++) v[n*LW +: LW] = LW'(n);
    return v;
  endfunction

  task automatic model(input logic [N-1:0] s, input logic [NE-1:0] en, output exp_t x);
    int g[NE]; int gb[NB]; int lab[N]; int labn[N];
    bit full[NE]; bit bfl[NB]; bit tch[N]; bit incl[N]; bit grw[N];
    for (int e = 0; e < NE; e++) g[e] = 0;
    for (int b = 0; b < NB; b++) gb[b] = 0;
    for (int n = 0; n < N; n++) lab[n] = n;
    x.done = 0; x.ovf = 0; x.cycles = 0;
    for (int it = 1; it <= MAXC; it++) begin
      bit anyg, chg;
      anyg = 0; chg = 0;
      for (int e = 0; e < NE; e++) full[e] = (g[e] == 2) && en[e];
      for (int b = 0; b < NB; b++) bfl[b] = (gb[b] == 2);
      for (int n = 0; n < N; n++) begin
        int r, c;
        r = n / COLS; c = n % COLS;
        tch[n] = (c == 0 && bfl[r]) || (c == COLS - 1 && bfl[ROWS + r]);
        incl[n] = s[n] || tch[n];
        labn[n] = lab[n];
        if (c > 0 && full[hx(r, c - 1)]) begin incl[n] = 1; if (lab[n-1] < labn[n]) labn[n] = lab[n-1]; end
        if (c < COLS - 1 && full[hx(r, c)]) begin incl[n] = 1; if (lab[n+1] < labn[n]) labn[n] = lab[n+1]; end
        if (r > 0 && full[vx(r - 1, c)]) begin incl[n] = 1; if (lab[n-COLS] < labn[n]) labn[n] = lab[n-COLS]; end
        if (r < ROWS - 1 && full[vx(r, c)]) begin incl[n] = 1; if (lab[n+COLS] < labn[n]) labn[n] = lab[n+COLS]; end
      end
      for (int n = 0; n < N; n++) begin
        bit par, bnd;
        par = 0; bnd = 0;
        for (int k = 0; k < N; k++)
          if (lab[k] == lab[n]) begin par ^= s[k]; bnd |= tch[k]; end
        grw[n] = incl[n] && par && !bnd;
        anyg |= grw[n];
        chg  |= (labn[n] != lab[n]);
      end
      if (!anyg && !chg) begin x.done = 1; x.cycles = it; break; end
      if (it == MAXC) begin x.ovf = 1; x.cycles = it; break; end
      for (int n = 0; n < N; n++) lab[n] = labn[n];
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS - 1; c++)
          if (en[hx(r, c)]) begin
            g[hx(r, c)] += int'(grw[r*COLS+c]) + int'(grw[r*COLS+c+1]);
            if (g[hx(r, c)] > 2) g[hx(r, c)] = 2;
          end
      for (int r = 0; r < ROWS - 1; r++)
        for (int c = 0; c < COLS; c++)
          if (en[vx(r, c)]) begin
            g[vx(r, c)] += int'(grw[r*COLS+c]) + int'(grw[(r+1)*COLS+c]);
            if (g[vx(r, c)] > 2) g[vx(r, c)] = 2;
          end
      for (int r = 0; r < ROWS; r++) begin
        if (grw[r*COLS]) gb[r] = (gb[r] == 2) ? 2 : gb[r] + 1;
        if (grw[r*COLS+COLS-1]) gb[ROWS+r] = (gb[ROWS+r] == 2) ? 2 : gb[ROWS+r] + 1;
      end
    end
    for (int e = 0; e < NE; e++) x.ef[e] = (g[e] == 2) && en[e];
    for (int b = 0; b < NB; b++) x.bf[b] = (gb[b] == 2);
    for (int n = 0; n < N; n++) x.lab[n*LW +: LW] = LW'(lab[n]);
  endtask

  task automatic run_frame(input logic [N-1:0] s, input logic [NE-1:0] m, input bit mg);
    logic [NE-1:0] en;
    exp_t x;
    en = m;
    if (!mg) for (int r = 0; r < ROWS; r++) en[hx(r, SEAM - 1)] = 1'b0;
    model(s, en, x);
    sb_q.push_back(x);
    @(negedge clk);
    syn = s; mask = m; merged = mg; load = 1'b1;
    @(negedge clk);
    load = 1'b0; cyc = 0; busy = 1;
    wait (!busy);
    @(negedge clk);
  endtask

  // monitor: pops expected result when the run ends
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (busy) begin
        cyc++;
        if (done || ovf) begin
          exp_t x;
          x = sb_q.pop_front();
          chk(done == x.done, "R6", "done flag", 128'(done), 128'(x.done));
          chk(ovf == x.ovf, "R7", "overflow flag", 128'(ovf), 128'(x.ovf));
          chk(cyc == x.cycles, "R6", "iteration count", 128'(cyc), 128'(x.cycles));
          chk(edge_full == x.ef, "R3", "edge map", 128'(edge_full), 128'(x.ef));
          chk(bnd_full == x.bf, "R10", "boundary map", 128'(bnd_full), 128'(x.bf));
          chk(label == x.lab, "R4", "labels", 128'(label), 128'(x.lab));
          last_cyc = cyc;
          busy = 0;
        end else if (cyc > MAXC + 5) begin
          chk(0, "R6", "run never ended", 128'(cyc), 128'(MAXC));
          void'(sb_q.pop_front());
          busy = 0;
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [N-1:0]  s;
    logic [NE-1:0] m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!done && !ovf, "R1", "flags after reset", 128'({done, ovf}), 128'(0));
    chk(edge_full == '0 && bnd_full == '0, "R1", "edges after reset",
        128'({edge_full, bnd_full}), 128'(0));
    chk(label == ident_labels(), "R1", "labels after reset", 128'(label), 128'(ident_labels()));

    // empty frame: one iteration, labels unchanged
    run_frame('0, '1, 1'b1);
    chk(last_cyc == 1, "R6", "empty frame iterations", 128'(last_cyc), 128'(1));
    chk(label == ident_labels(), "R1", "empty frame labels", 128'(label), 128'(ident_labels()));

    // corner syndrome at node 0 reaching left boundary
    s = '0; s[0] = 1'b1;
    run_frame(s, '1, 1'b1);
    chk(last_cyc == 4, "R5", "corner iterations", 128'(last_cyc), 128'(4));
    chk(bnd_full[0] == 1'b1, "R10", "left boundary row0", 128'(bnd_full), 128'(1));
    chk(label[1*LW +: LW] == 0 && label[5*LW +: LW] == 0, "R4", "corner merged labels",
        128'({label[1*LW +: LW], label[5*LW +: LW]}), 128'(0));

    // pair straddling the seam
    s = '0; s[6] = 1'b1; s[7] = 1'b1;
    run_frame(s, '1, 1'b1);
    chk(edge_full[hx(1, 1)] == 1'b1, "R2", "both ends grow in one cycle",
        128'(edge_full[hx(1, 1)]), 128'(1));
    chk(label[6*LW +: LW] == label[7*LW +: LW], "R9", "merged mode joins pair",
        128'(label[7*LW +: LW]), 128'(label[6*LW +: LW]));
    run_frame(s, '1, 1'b0);
    chk(label[6*LW +: LW] != label[7*LW +: LW], "R9", "single mode splits pair",
        128'(label[7*LW +: LW]), 128'(label[6*LW +: LW]));
    chk(label[7*LW +: LW] >= LW'(SEAM), "R9", "right half label",
        128'(label[7*LW +: LW]), 128'(SEAM));

    // walled-in node -> overflow
    s = '0; s[6] = 1'b1;
    m = '1; m[hx(1, 0)] = 0; m[hx(1, 1)] = 0; m[vx(0, 1)] = 0; m[vx(1, 1)] = 0;
    run_frame(s, m, 1'b1);
    chk(ovf && !done, "R7", "walled node overflows", 128'({ovf, done}), 128'(2));
    chk(last_cyc == MAXC, "R7", "overflow iteration", 128'(last_cyc), 128'(MAXC));
    chk(!edge_full[hx(1, 0)] && !edge_full[hx(1, 1)] && !edge_full[vx(0, 1)] && !edge_full[vx(1, 1)],
        "R8", "masked edges stay open", 128'(edge_full), 128'(0));

    // random frames in both modes
    for (int t = 0; t < 40; t++) begin
      for (int n = 0; n < N; n++) s[n] = ($urandom % 5) == 0;
      for (int e = 0; e < NE; e++) m[e] = ($urandom % 12) != 0;
      run_frame(s, m, 1'($urandom % 2));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule